// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block serves the guest side of a virtualized interrupt CPU interface. It holds a small array of list entries, each with a 25-bit interrupt ID, a priority, a group bit, a two-bit state and a three-bit source-CPU field. A hypervisor-side write port loads entries one at a time. It also loads a control word that holds the interface enable, a priority mask, a routing-mode bit and the active-priority bit vector.

The guest reads a single 32-bit alias acknowledge register, and the read itself is the acknowledge. The unit picks the most urgent pending entry. It checks that entry against the enable, the mask and the running priority. It then either returns the spurious code 1023 or returns the entry's ID. When it returns the ID, the unit moves the entry to active and records the entry's priority in the active-priority vector. Only Group 1 entries can be acknowledged here. When a Group 0 entry is the most urgent, the read yields the spurious code and leaves everything untouched. Writes to the alias register are ignored.

Top module: `vack_unit`

## Requirements
- R1: Read data bits [31:25] are always zero. In affinity mode (`hv_ctl_affinity`=1), bits [24:0] carry the full 25-bit ID of the acknowledged entry.
- R2: A read returns 1023 when no entry is in the pending state. Entry state codes are 00 invalid, 01 pending, 10 active and 11 pending-and-active.
- R3: The candidate is the entry in state 01 with the numerically lowest priority. Ties go to the lowest entry index. Entries in any other state are never chosen.
- R4: If the candidate's group bit is 0, the read returns 1023 and no entry state and no active-priority bit changes.
- R5: If the candidate is signalled and its group bit is 1, the read returns its ID. At the same clock edge the entry's state becomes 10 and bit p of the active-priority vector is set, where p is the entry's priority. Both changes are visible on the outputs one cycle after the read is presented.
- R6: The candidate is signalled only if its priority is strictly below the priority mask and strictly below the index of the lowest set active-priority bit. When no active-priority bit is set, only the mask applies. Otherwise the read returns 1023 and changes nothing.
- R7: With the interface enable at 0, every read returns 1023 and changes nothing.
- R8: In legacy mode (`hv_ctl_affinity`=0), bits [24:13] of an acknowledged value are zero and bits [9:0] are ID[9:0]. Bits [12:10] carry the source-CPU field when the ID is below 16 and are zero otherwise.
- R9: A guest access with `gst_write`=1 is ignored. The read data, the entry states and the active-priority vector keep their values.
- R10: After reset the read data is 0, every entry is invalid (00), the active-priority vector is 0 and the interface is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_ent_we | input | 1 | Load one list entry |
| hv_ent_idx | input | IDX_W | Index of the entry to load |
| hv_ent_id | input | 25 | Interrupt ID for the entry |
| hv_ent_prio | input | PRIO_W | Priority (lower value is more urgent) |
| hv_ent_grp1 | input | 1 | 1 = Group 1, 0 = Group 0 |
| hv_ent_state | input | 2 | State code for the entry |
| hv_ent_src | input | 3 | Source CPU for software-generated IDs |
| hv_ctl_we | input | 1 | Load the control word |
| hv_ctl_enable | input | 1 | Interface signalling enable |
| hv_ctl_pmask | input | PRIO_W | Priority mask |
| hv_ctl_affinity | input | 1 | 1 = affinity read format, 0 = legacy |
| hv_ctl_apr | input | 2**PRIO_W | Active-priority vector value |
| gst_valid | input | 1 | Guest access to the alias register |
| gst_write | input | 1 | Access is a write (ignored) |
| gst_rdata | output | 32 | Registered read data |
| ent_state_o | output | 2*N | State codes of all entries, entry i at [2i+1:2i] |
| apr_o | output | 2**PRIO_W | Current active-priority vector |

## Verification
The acknowledge assertion identifies a real acknowledge by a return value other than 1023. It therefore assumes that no entry holds an ID whose low ten bits fall in 1020 to 1023. The bench keeps every ID it loads out of that range. The stability properties assume that the hypervisor port is idle during the guest access they watch. The bench never loads entries or control in the cycle a guest access is presented, and it never programs a priority mask at its maximum value together with a duplicate active bit.

// File: rtl/vack_pkg.sv
// Package: shared constants and types for the virtual acknowledge unit.
// Assumes a 32-bit register view and 25-bit interrupt IDs.
package vack_pkg;
    localparam int DATA_W    = 32;
    localparam int ID_W      = 25;
    localparam int SRC_W     = 3;
    localparam int SGI_LIMIT = 16;
    localparam logic [DATA_W-1:0] SPURIOUS = 32'd1023;

    typedef enum logic [1:0] {
        ST_INVALID = 2'b00,
        ST_PENDING = 2'b01,
        ST_ACTIVE  = 2'b10,
        ST_PEND_ACT = 2'b11
    } ent_state_e;
endpackage

// File: rtl/vack_entry_bank.sv
// Module: vack_entry_bank
// Holds N list entries. A hypervisor load takes precedence over an
// acknowledge in the same cycle. An acknowledge moves the named entry
// to the active state. Assumes ack_en is only raised for a pending entry.
module vack_entry_bank
    import vack_pkg::*;
#(
    parameter int N      = 4,
    parameter int PRIO_W = 5,
    parameter int IDX_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ID_W-1:0]             wr_id,
    input  logic [PRIO_W-1:0]           wr_prio,
    input  logic                        wr_grp1,
    input  logic [1:0]                  wr_state,
    input  logic [SRC_W-1:0]            wr_src,
    input  logic                        ack_en,
    input  logic [IDX_W-1:0]            ack_idx,
    output logic [N-1:0][ID_W-1:0]      ent_id,
    output logic [N-1:0][PRIO_W-1:0]    ent_prio,
    output logic [N-1:0]                ent_grp1,
    output logic [N-1:0][1:0]           ent_state,
    output logic [N-1:0][SRC_W-1:0]     ent_src
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic hit_wr;
        logic hit_ack;
        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
        assign hit_ack = ack_en && (ack_idx == IDX_W'(g));

        // Static fields: change only on a hypervisor load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_id[g]   <= '0;
                ent_prio[g] <= '0;
                ent_grp1[g] <= 1'b0;
                ent_src[g]  <= '0;
            end else if (hit_wr) begin
                ent_id[g]   <= wr_id;
                ent_prio[g] <= wr_prio;
                ent_grp1[g] <= wr_grp1;
                ent_src[g]  <= wr_src;
            end
        end

        // State field: loaded by the hypervisor or advanced by an acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_state[g] <= ST_INVALID;
            end else if (hit_wr) begin
                ent_state[g] <= wr_state;
            end else if (hit_ack) begin
                ent_state[g] <= ST_ACTIVE;
            end
        end
    end
endmodule

// File: rtl/vack_prio_sel.sv
// Module: vack_prio_sel
// Finds the pending entry with the numerically lowest priority. Ties go
// to the lowest index. Purely combinational; a linear scan suits small N.
module vack_prio_sel
    import vack_pkg::*;
#(
    parameter int N      = 4,
    parameter int PRIO_W = 5,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0][PRIO_W-1:0] ent_prio,
    input  logic [N-1:0][1:0]        ent_state,
    output logic                     sel_hit,
    output logic [IDX_W-1:0]         sel_idx,
    output logic [PRIO_W-1:0]        sel_prio
);
    // Scan entries in index order; a strict compare keeps the earliest tie.
    always_comb begin
        sel_hit  = 1'b0;
        sel_idx  = '0;
        sel_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (ent_state[i] == ST_PENDING && (!sel_hit || ent_prio[i] < sel_prio)) begin
                sel_hit  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_prio = ent_prio[i];
            end
        end
    end
endmodule

// File: rtl/vack_rdfmt.sv
// Module: vack_rdfmt
// Builds the 32-bit read value: the spurious code or the entry's ID in
// affinity or legacy layout. Combinational; the caller registers it.
module vack_rdfmt
    import vack_pkg::*;
(
    input  logic              give_id,
    input  logic              affinity,
    input  logic [ID_W-1:0]   id,
    input  logic [SRC_W-1:0]  src,
    output logic [DATA_W-1:0] data
);
    logic is_sgi;
    assign is_sgi = (id < ID_W'(SGI_LIMIT));

    // Select the layout of the returned word.
    always_comb begin
        if (!give_id) begin
            data = SPURIOUS;
        end else if (affinity) begin
            data = {{(DATA_W-ID_W){1'b0}}, id};
        end else begin
            data = {19'd0, (is_sgi ? src : {SRC_W{1'b0}}), id[9:0]};
        end
    end
endmodule

// File: rtl/vack_unit.sv
// Module: vack_unit (top)
// Read-triggered acknowledge for a virtual CPU interface. A guest read
// selects the most urgent pending entry. A signalled Group 1 entry is
// acknowledged; anything else yields the spurious code. Assumes
// hypervisor loads and guest accesses are not issued in the same cycle.
module vack_unit
    import vack_pkg::*;
#(
    parameter int N      = 4,
    parameter int PRIO_W = 5,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1,
    localparam int NUM_PRIO = 1 << PRIO_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hv_ent_we,
    input  logic [IDX_W-1:0]      hv_ent_idx,
    input  logic [24:0]           hv_ent_id,
    input  logic [PRIO_W-1:0]     hv_ent_prio,
    input  logic                  hv_ent_grp1,
    input  logic [1:0]            hv_ent_state,
    input  logic [2:0]            hv_ent_src,
    input  logic                  hv_ctl_we,
    input  logic                  hv_ctl_enable,
    input  logic [PRIO_W-1:0]     hv_ctl_pmask,
    input  logic                  hv_ctl_affinity,
    input  logic [NUM_PRIO-1:0]   hv_ctl_apr,
    input  logic                  gst_valid,
    input  logic                  gst_write,
    output logic [31:0]           gst_rdata,
    output logic [2*N-1:0]        ent_state_o,
    output logic [NUM_PRIO-1:0]   apr_o
);
    logic                     en_q;
    logic                     aff_q;
    logic [PRIO_W-1:0]        pmask_q;
    logic [NUM_PRIO-1:0]      apr_q;

    logic [N-1:0][ID_W-1:0]   ent_id;
    logic [N-1:0][PRIO_W-1:0] ent_prio;
    logic [N-1:0]             ent_grp1;
    logic [N-1:0][1:0]        ent_state;
    logic [N-1:0][SRC_W-1:0]  ent_src;

    logic                     sel_hit;
    logic [IDX_W-1:0]         sel_idx;
    logic [PRIO_W-1:0]        sel_prio;
    logic [PRIO_W:0]          run_prio;
    logic                     rd_req;
    logic                     signalled;
    logic                     do_ack;
    logic [DATA_W-1:0]        fmt_data;

    // Control word: enable, mask and layout mode, loaded by the hypervisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            aff_q   <= 1'b0;
            pmask_q <= '0;
        end else if (hv_ctl_we) begin
            en_q    <= hv_ctl_enable;
            aff_q   <= hv_ctl_affinity;
            pmask_q <= hv_ctl_pmask;
        end
    end

    vack_entry_bank #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hv_ent_we),
        .wr_idx    (hv_ent_idx),
        .wr_id     (hv_ent_id),
        .wr_prio   (hv_ent_prio),
        .wr_grp1   (hv_ent_grp1),
        .wr_state  (hv_ent_state),
        .wr_src    (hv_ent_src),
        .ack_en    (do_ack),
        .ack_idx   (sel_idx),
        .ent_id    (ent_id),
        .ent_prio  (ent_prio),
        .ent_grp1  (ent_grp1),
        .ent_state (ent_state),
        .ent_src   (ent_src)
    );

    vack_prio_sel #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) sel_i (
        .ent_prio  (ent_prio),
        .ent_state (ent_state),
        .sel_hit   (sel_hit),
        .sel_idx   (sel_idx),
        .sel_prio  (sel_prio)
    );

    // Running priority: index of the lowest set active bit, or NUM_PRIO if none.
    always_comb begin
        run_prio = (PRIO_W+1)'(NUM_PRIO);
        for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (apr_q[i]) run_prio = (PRIO_W+1)'(i);
        end
    end

    assign rd_req    = gst_valid && !gst_write;
    assign signalled = en_q && sel_hit && (sel_prio < pmask_q)
                       && ({1'b0, sel_prio} < run_prio);
    assign do_ack    = rd_req && signalled && ent_grp1[sel_idx];

    vack_rdfmt fmt_i (
        .give_id  (signalled && ent_grp1[sel_idx]),
        .affinity (aff_q),
        .id       (ent_id[sel_idx]),
        .src      (ent_src[sel_idx]),
        .data     (fmt_data)
    );

    // Read data register: updated only by a guest read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gst_rdata <= '0;
        end else if (rd_req) begin
            gst_rdata <= fmt_data;
        end
    end

    // Active-priority vector: hypervisor load, or set on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apr_q <= '0;
        end else if (hv_ctl_we) begin
            apr_q <= hv_ctl_apr;
        end else if (do_ack) begin
            apr_q[sel_prio] <= 1'b1;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_st_out
        assign ent_state_o[2*g +: 2] = ent_state[g];
    end
    assign apr_o = apr_q;
endmodule

// File: rtl/vack_unit_chk.sv
// Module: vack_unit_chk
// Temporal checks on the acknowledge unit, bound to every instance.
// Assumes no entry ID has low ten bits in the reserved 1020..1023 range.
module vack_unit_chk #(
    parameter int N        = 4,
    parameter int NUM_PRIO = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                gst_valid,
    input logic                gst_write,
    input logic                hv_ent_we,
    input logic                hv_ctl_we,
    input logic                en_q,
    input logic                aff_q,
    input logic [31:0]         gst_rdata,
    input logic [2*N-1:0]      ent_state_o,
    input logic [NUM_PRIO-1:0] apr_o
);
    logic rd_quiet;
    assign rd_quiet = gst_valid && !gst_write && !hv_ent_we && !hv_ctl_we;

    p_top_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gst_rdata[31:25] == 7'd0);

    p_disabled_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_quiet && !en_q) |=> (gst_rdata == 32'd1023) && $stable(ent_state_o) && $stable(apr_o));

    p_ack_sets_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_quiet |=> ((gst_rdata != 32'd1023) == ($countones(apr_o) == $countones($past(apr_o)) + 1)));

    p_legacy_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_quiet && !aff_q) |=> (gst_rdata[24:13] == 12'd0));

    p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gst_valid && gst_write && !hv_ent_we && !hv_ctl_we)
        |=> $stable(gst_rdata) && $stable(ent_state_o) && $stable(apr_o));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gst_valid && !hv_ent_we && !hv_ctl_we)
        |=> $stable(gst_rdata) && $stable(ent_state_o) && $stable(apr_o));
endmodule

bind vack_unit vack_unit_chk #(.N(N), .NUM_PRIO(NUM_PRIO)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gst_valid   (gst_valid),
    .gst_write   (gst_write),
    .hv_ent_we   (hv_ent_we),
    .hv_ctl_we   (hv_ctl_we),
    .en_q        (en_q),
    .aff_q       (aff_q),
    .gst_rdata   (gst_rdata),
    .ent_state_o (ent_state_o),
    .apr_o       (apr_o)
);

// File: tb/vack_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus a seeded sweep, checked against a
// model built from the requirements.
module vack_unit_tb_top;
    localparam int N = 4;
    localparam int PRIO_W = 5;
    localparam int NP = 1 << PRIO_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv_ent_we = 0;
    logic [1:0] hv_ent_idx = 0;
    logic [24:0] hv_ent_id = 0;
    logic [PRIO_W-1:0] hv_ent_prio = 0;
    logic hv_ent_grp1 = 0;
    logic [1:0] hv_ent_state = 0;
    logic [2:0] hv_ent_src = 0;
    logic hv_ctl_we = 0;
    logic hv_ctl_enable = 0;
    logic [PRIO_W-1:0] hv_ctl_pmask = 0;
    logic hv_ctl_affinity = 0;
    logic [NP-1:0] hv_ctl_apr = 0;
    logic gst_valid = 0;
    logic gst_write = 0;
    logic [31:0] gst_rdata;
    logic [2*N-1:0] ent_state_o;
    logic [NP-1:0] apr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    // Reference state
    logic [24:0] m_id [N];
    logic [PRIO_W-1:0] m_prio [N];
    logic m_grp [N];
    logic [1:0] m_st [N];
    logic [2:0] m_src [N];
    logic m_en = 0, m_aff = 0;
    logic [PRIO_W-1:0] m_mask = 0;
    logic [NP-1:0] m_apr = 0;
    logic [31:0] m_rd = 0;

    always #2 clk = ~clk;

    vack_unit #(.N(N), .PRIO_W(PRIO_W)) dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] m_states();
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = m_st[i];
        return v;
    endfunction

    task automatic load_ent(input int i, input logic [24:0] id, input int pr,
                            input logic g1, input logic [1:0] st, input logic [2:0] src);
        @(negedge clk);
        hv_ent_we = 1; hv_ent_idx = 2'(i); hv_ent_id = id; hv_ent_prio = PRIO_W'(pr);
        hv_ent_grp1 = g1; hv_ent_state = st; hv_ent_src = src;
        m_id[i] = id; m_prio[i] = PRIO_W'(pr); m_grp[i] = g1; m_st[i] = st; m_src[i] = src;
        @(negedge clk);
        hv_ent_we = 0;
    endtask

    task automatic load_ctl(input logic en, input int mask, input logic aff, input logic [NP-1:0] apr);
        @(negedge clk);
        hv_ctl_we = 1; hv_ctl_enable = en; hv_ctl_pmask = PRIO_W'(mask);
        hv_ctl_affinity = aff; hv_ctl_apr = apr;
        m_en = en; m_mask = PRIO_W'(mask); m_aff = aff; m_apr = apr;
        @(negedge clk);
        hv_ctl_we = 0;
    endtask

    // Model of one guest read, written from R1..R8.
    task automatic model_read();
        int best = -1;
        int run = NP;
        for (int i = NP - 1; i >= 0; i--) if (m_apr[i]) run = i;
        for (int i = 0; i < N; i++)
            if (m_st[i] == 2'b01 && (best < 0 || m_prio[i] < m_prio[best])) best = i;
        if (!m_en || best < 0 || int'(m_prio[best]) >= int'(m_mask)
            || int'(m_prio[best]) >= run || !m_grp[best]) begin
            m_rd = 32'd1023;
        end else begin
            if (m_aff) m_rd = {7'd0, m_id[best]};
            else m_rd = {19'd0, (m_id[best] < 16) ? m_src[best] : 3'd0, m_id[best][9:0]};
            m_st[best] = 2'b10;
            m_apr[m_prio[best]] = 1'b1;
        end
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        gst_valid = 1; gst_write = 0;
        model_read();
        @(negedge clk);
        gst_valid = 0;
        chk({tag, " rdata"}, 64'(gst_rdata), 64'(m_rd));
        chk({tag, " state"}, 64'(ent_state_o), 64'(m_states()));
        chk({tag, " apr"}, 64'(apr_o), 64'(m_apr));
    endtask

    task automatic do_write(input string tag);
        @(negedge clk);
        gst_valid = 1; gst_write = 1;
        @(negedge clk);
        gst_valid = 0; gst_write = 0;
        chk({tag, " rdata"}, 64'(gst_rdata), 64'(m_rd));
        chk({tag, " state"}, 64'(ent_state_o), 64'(m_states()));
        chk({tag, " apr"}, 64'(apr_o), 64'(m_apr));
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[15:0], seed[31:16]};
    endfunction

    function automatic logic [24:0] safe_id(input logic [31:0] r);
        logic [24:0] id;
        id = r[0] ? 25'(r[8:4]) : r[31:7];
        if (id[9:0] >= 10'd1020) id[9:0] = 10'd7;
        return id;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m_id[i] = 0; m_prio[i] = 0; m_grp[i] = 0; m_st[i] = 0; m_src[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset values
        chk("R10 rdata", 64'(gst_rdata), 64'd0);
        chk("R10 state", 64'(ent_state_o), 64'd0);
        chk("R10 apr", 64'(apr_o), 64'd0);
        // R7 / R10: disabled after reset, pending entry present
        load_ent(0, 25'd40, 1, 1, 2'b01, 0);
        do_read("R7 R10 disabled");
        chk("R7 literal", 64'(gst_rdata), 64'd1023);
        // R2: nothing pending
        load_ent(0, 25'd40, 1, 1, 2'b10, 0);
        load_ctl(1, 31, 1, '0);
        do_read("R2 none pending");
        chk("R2 literal", 64'(gst_rdata), 64'd1023);
        // R3: tie, lower index wins; active entry with better value skipped
        load_ent(0, 25'd50, 0, 1, 2'b11, 0);
        load_ent(1, 25'd51, 3, 1, 2'b01, 0);
        load_ent(2, 25'd52, 3, 1, 2'b01, 0);
        load_ent(3, 25'd53, 4, 1, 2'b01, 0);
        do_read("R3 tie");
        chk("R3 literal", 64'(gst_rdata), 64'd51);
        chk("R5 state", 64'(ent_state_o[3:2]), 64'd2);
        chk("R5 apr bit", 64'(apr_o[3]), 64'd1);
        // R6: running priority 3 blocks the other prio-3 entry
        do_read("R6 running");
        chk("R6 literal", 64'(gst_rdata), 64'd1023);
        // R6: mask boundary
        load_ctl(1, 4, 1, '0);
        load_ent(2, 25'd52, 4, 1, 2'b01, 0);
        load_ent(3, 25'd53, 9, 1, 2'b00, 0);
        load_ent(1, 25'd51, 4, 1, 2'b00, 0);
        do_read("R6 at mask");
        chk("R6 mask literal", 64'(gst_rdata), 64'd1023);
        load_ctl(1, 5, 1, '0);
        do_read("R6 below mask");
        chk("R6 below literal", 64'(gst_rdata), 64'd52);
        // R4: group 0 candidate blocks a group 1 entry behind it
        load_ctl(1, 31, 1, '0);
        load_ent(0, 25'd60, 1, 0, 2'b01, 0);
        load_ent(1, 25'd61, 2, 1, 2'b01, 0);
        do_read("R4 group0");
        chk("R4 literal", 64'(gst_rdata), 64'd1023);
        // R9: write access ignored
        do_write("R9 write");
        // R1: affinity returns full ID
        load_ent(0, 25'h1ABCD5, 0, 1, 2'b01, 0);
        do_read("R1 affinity");
        chk("R1 literal", 64'(gst_rdata), 64'h001ABCD5);
        // R8: legacy formats
        load_ctl(1, 31, 0, '0);
        load_ent(0, 25'd5, 0, 1, 2'b01, 3'd6);
        do_read("R8 sgi");
        chk("R8 sgi literal", 64'(gst_rdata), 64'h1805);
        load_ent(0, 25'h12345, 0, 1, 2'b01, 3'd6);
        load_ctl(1, 31, 0, '0);
        do_read("R8 wide id");
        chk("R8 wide literal", 64'(gst_rdata), 64'h345);
        load_ent(0, 25'd16, 0, 1, 2'b01, 3'd7);
        load_ctl(1, 31, 0, '0);
        do_read("R8 non-sgi");
        chk("R8 nonsgi literal", 64'(gst_rdata), 64'd16);
        // Sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int t = 0; t < 400; t++) begin
            logic [31:0] r;
            logic [NP-1:0] apr;
            for (int i = 0; i < N; i++) begin
                r = rnd();
                load_ent(i, safe_id(rnd()), int'(r[2:0]), r[3], r[5:4], r[8:6]);
            end
            r = rnd();
            apr = '0;
            if (r[0]) apr[r[5:1] % 10] = 1'b1;
            load_ctl(r[6] | r[7], r[8] ? 31 : int'(r[12:9]), r[13], apr);
            do_read("R3 R5 R6 sweep first");
            do_read("R6 R5 sweep second");
            do_write("R9 sweep");
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule